// File: doc/BRIEF.md
# Almost-Flag Threshold Loader

This block holds the two thresholds that a FIFO's almost-empty and almost-full flags compare against. Software or a host loads them through the FIFO's own narrow write data bus. Each threshold is split into a low part and a high part. That gives four slot registers, each as wide as the data bus. The slots are written one at a time in a fixed rotating order, and an internal slot pointer steps after each load and wraps after the fourth slot.

The load pin has two roles. While reset is held, its level chooses the operating mode: low selects programmable thresholds, high locks the thresholds at their defaults. After reset, holding it low together with the write enable turns each write-clock edge into a slot load instead of a data write.

A separate read-clock path reads the slots back in the same rotating order, using its own pointer. The two assembled thresholds are presented continuously to the flag logic, which lives outside this block.

Top module: `thr_offset_loader`

## Requirements
- R1: While `rst_n` is low, each clock edge returns both thresholds to DEFAULT_OFFSET (7), clears `rb_data` to 0, and returns both slot pointers to slot 0.
- R2: Programmable mode is enabled only if `ld_n` was low during reset. If it was high, no write-clock edge changes a threshold and no read-clock edge changes `rb_data` until the next reset.
- R3: In programmable mode, a rising `wr_clk` edge with `ld_n` low and `wr_en_n` low stores `wdata` into the slot the write pointer selects.
- R4: The slots are numbered 0 to 3 and visited in this order: 0 = empty threshold low part, 1 = empty threshold high part, 2 = full threshold low part, 3 = full threshold high part.
- R5: The load after slot 3 goes to slot 0 again.
- R6: A `wr_clk` edge with `ld_n` high or `wr_en_n` high leaves both the write pointer and every slot unchanged.
- R7: Each threshold is the concatenation {high part, low part} of its two slots, cut to log2(DEPTH) bits. With the defaults, this is 14 bits taken from the 18 bits of the two slots.
- R8: In programmable mode, a rising `rd_clk` edge with `ld_n`, `rd_en_a_n` and `rd_en_b_n` all low copies the slot the read pointer selects into `rb_data`. The read pointer then advances in the order of R4 and wraps as in R5.
- R9: A `rd_clk` edge without that full qualification leaves `rb_data` and the read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; slot loads happen on its rising edge |
| rd_clk | input | 1 | Read clock; read-back happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, seen in both clock domains |
| ld_n | input | 1 | Active-low load select; its level during reset picks the mode |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| wdata | input | SLOT_W (9) | Shared write data bus |
| empty_offset | output | log2(DEPTH) (14) | Assembled almost-empty threshold |
| full_offset | output | log2(DEPTH) (14) | Assembled almost-full threshold |
| rb_data | output | SLOT_W (9) | Slot contents read back |

## Verification
Some rules are checked by the assertions on every cycle. An unqualified or locked write edge must leave both thresholds untouched. A load at slot 0 must show the bus value in the low bits of the empty threshold. Both pointers must wrap from slot 3 to slot 0. An unqualified read edge must hold `rb_data`. Other behaviour can only be shown by the bench's scenarios: the full four-slot order, the truncation when the full threshold's high part is all ones, the pointer being reset in the middle of a sequence, and the lock-out that follows a reset with the load pin high.

// File: rtl/thr_pkg.sv
// Package: shared slot naming for the threshold loader.
// Assumes exactly four slots, visited in a fixed rotating order.
package thr_pkg;

    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    localparam int NUM_SLOTS = 4;

    // Successor of a slot in the rotation; slot 3 wraps back to slot 0.
    function automatic slot_e slot_after(slot_e cur);
        case (cur)
            SLOT_E_LO: return SLOT_E_HI;
            SLOT_E_HI: return SLOT_F_LO;
            SLOT_F_LO: return SLOT_F_HI;
            default:   return SLOT_E_LO;
        endcase
    endfunction

endpackage

// File: rtl/thr_mode_latch.sv
// Module: captures the operating mode while reset is held.
// prog goes high when the load pin was low during reset.
// Assumes the clock runs during reset. One instance sits in each clock domain.
module thr_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_n,
    output logic prog
);

    // Purpose: sample the inverted load pin while reset is active, hold it after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog <= ~ld_n;
        end
    end

endmodule

// File: rtl/thr_slot_ptr.sv
// Module: rotating slot pointer.
// Steps through the four slots in order when step is high and wraps after slot 3.
// Assumes synchronous active-low reset to slot 0.
module thr_slot_ptr
    import thr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    output slot_e sel
);

    // Purpose: reset to slot 0, otherwise advance on each qualified step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= SLOT_E_LO;
        end else if (step) begin
            sel <= slot_after(sel);
        end
    end

endmodule

// File: rtl/thr_slot_bank.sv
// Module: the four slot registers in the write clock domain.
// Slot 0 and slot 2 reset to the low bits of DEFAULT_OFFSET; slot 1 and slot 3 reset to its high bits.
// Assumes wr_en is already qualified by mode, load select and write enable.
module thr_slot_bank
    import thr_pkg::*;
#(
    parameter int SLOT_W         = 9,
    parameter int DEFAULT_OFFSET = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  slot_e                             sel,
    input  logic [SLOT_W-1:0]                 wdata,
    output logic [NUM_SLOTS-1:0][SLOT_W-1:0]  slots
);

    localparam logic [2*SLOT_W-1:0] DEF_FULL = (2*SLOT_W)'(DEFAULT_OFFSET);
    localparam logic [SLOT_W-1:0]   DEF_LO   = DEF_FULL[SLOT_W-1:0];
    localparam logic [SLOT_W-1:0]   DEF_HI   = DEF_FULL[2*SLOT_W-1:SLOT_W];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [SLOT_W-1:0] RST_VAL = (g % 2 == 0) ? DEF_LO : DEF_HI;

        // Purpose: load this slot when it is selected and a qualified write occurs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= RST_VAL;
            end else if (wr_en && (sel == slot_e'(g))) begin
                slots[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/thr_readback.sv
// Module: read-back register in the read clock domain.
// Assumes the slots are not loaded while a read-back is in progress, so no synchronizer is used.
module thr_readback
    import thr_pkg::*;
#(
    parameter int SLOT_W = 9
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  slot_e                             sel,
    input  logic [NUM_SLOTS-1:0][SLOT_W-1:0]  slots,
    output logic [SLOT_W-1:0]                 rb_data
);

    // Purpose: capture the selected slot on a qualified read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_data <= '0;
        end else if (rd_en) begin
            rb_data <= slots[sel];
        end
    end

endmodule

// File: rtl/thr_offset_loader.sv
// Module: top of the threshold loader.
// Holds the almost-empty and almost-full thresholds, loaded slot by slot over the write bus
// and read back over a separate read clock.
// Assumes rst_n is held for at least one edge of each clock, with both clocks running.
module thr_offset_loader
    import thr_pkg::*;
#(
    parameter int SLOT_W         = 9,
    parameter int DEPTH          = 16384,
    parameter int DEFAULT_OFFSET = 7
) (
    input  logic                      wr_clk,
    input  logic                      rd_clk,
    input  logic                      rst_n,
    input  logic                      ld_n,
    input  logic                      wr_en_n,
    input  logic                      rd_en_a_n,
    input  logic                      rd_en_b_n,
    input  logic [SLOT_W-1:0]         wdata,
    output logic [$clog2(DEPTH)-1:0]  empty_offset,
    output logic [$clog2(DEPTH)-1:0]  full_offset,
    output logic [SLOT_W-1:0]         rb_data
);

    localparam int OFFS_W = $clog2(DEPTH);
    localparam int PAIR_W = 2 * SLOT_W;

    logic                             wr_prog;
    logic                             rd_prog;
    logic                             wr_load;
    logic                             rd_load;
    slot_e                            wr_sel;
    slot_e                            rd_sel;
    logic [NUM_SLOTS-1:0][SLOT_W-1:0] slots;
    logic [PAIR_W-1:0]                empty_pair;
    logic [PAIR_W-1:0]                full_pair;

    thr_mode_latch u_wr_mode (.clk(wr_clk), .rst_n(rst_n), .ld_n(ld_n), .prog(wr_prog));
    thr_mode_latch u_rd_mode (.clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n), .prog(rd_prog));

    // Purpose: qualify write-side loads and read-side read-backs.
    always_comb begin
        wr_load = wr_prog && !ld_n && !wr_en_n;
        rd_load = rd_prog && !ld_n && !rd_en_a_n && !rd_en_b_n;
    end

    thr_slot_ptr u_wr_ptr (.clk(wr_clk), .rst_n(rst_n), .step(wr_load), .sel(wr_sel));
    thr_slot_ptr u_rd_ptr (.clk(rd_clk), .rst_n(rst_n), .step(rd_load), .sel(rd_sel));

    thr_slot_bank #(.SLOT_W(SLOT_W), .DEFAULT_OFFSET(DEFAULT_OFFSET)) u_bank (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .wr_en (wr_load),
        .sel   (wr_sel),
        .wdata (wdata),
        .slots (slots)
    );

    thr_readback #(.SLOT_W(SLOT_W)) u_rb (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .rd_en   (rd_load),
        .sel     (rd_sel),
        .slots   (slots),
        .rb_data (rb_data)
    );

    // Purpose: join high and low parts, then fit them to the threshold width.
    always_comb begin
        empty_pair   = {slots[SLOT_E_HI], slots[SLOT_E_LO]};
        full_pair    = {slots[SLOT_F_HI], slots[SLOT_F_LO]};
        empty_offset = OFFS_W'(empty_pair);
        full_offset  = OFFS_W'(full_pair);
    end

endmodule

// File: rtl/thr_offset_loader_chk.sv
// Module: checker for thr_offset_loader, attached to it by bind.
// Assumes SLOT_W <= OFFS_W, so the low slot appears whole in a threshold.
module thr_offset_loader_chk #(
    parameter int SLOT_W = 9,
    parameter int OFFS_W = 14
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              wr_en_n,
    input logic              rd_en_a_n,
    input logic              rd_en_b_n,
    input logic [SLOT_W-1:0] wdata,
    input logic [OFFS_W-1:0] empty_offset,
    input logic [OFFS_W-1:0] full_offset,
    input logic [SLOT_W-1:0] rb_data,
    input logic              wr_prog,
    input logic              rd_prog,
    input logic [1:0]        wr_sel,
    input logic [1:0]        rd_sel
);

    // R6: an unqualified write edge changes neither threshold
    a_r6_idle_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (ld_n || wr_en_n) |=> ($stable(empty_offset) && $stable(full_offset)));

    // R2: in locked mode the thresholds never move
    a_r2_locked: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_prog |=> ($stable(empty_offset) && $stable(full_offset)));

    // R3: a load at slot 0 shows the bus value in the low bits of the empty threshold
    a_r3_slot0_load: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_prog && !ld_n && !wr_en_n && wr_sel == 2'd0)
        |=> (empty_offset[SLOT_W-1:0] == $past(wdata)));

    // R5: the write pointer wraps from slot 3 to slot 0
    a_r5_wr_wrap: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_prog && !ld_n && !wr_en_n && wr_sel == 2'd3) |=> (wr_sel == 2'd0));

    // R8: the read pointer wraps from slot 3 to slot 0
    a_r8_rd_wrap: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_prog && !ld_n && !rd_en_a_n && !rd_en_b_n && rd_sel == 2'd3) |=> (rd_sel == 2'd0));

    // R9: an unqualified read edge holds rb_data and the read pointer
    a_r9_rb_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(rd_prog && !ld_n && !rd_en_a_n && !rd_en_b_n) |=> ($stable(rb_data) && $stable(rd_sel)));

endmodule

bind thr_offset_loader thr_offset_loader_chk #(.SLOT_W(SLOT_W), .OFFS_W($clog2(DEPTH))) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .ld_n         (ld_n),
    .wr_en_n      (wr_en_n),
    .rd_en_a_n    (rd_en_a_n),
    .rd_en_b_n    (rd_en_b_n),
    .wdata        (wdata),
    .empty_offset (empty_offset),
    .full_offset  (full_offset),
    .rb_data      (rb_data),
    .wr_prog      (wr_prog),
    .rd_prog      (rd_prog),
    .wr_sel       (wr_sel),
    .rd_sel       (rd_sel)
);

// File: tb/test_thr_offset_loader.sv
// Bench: a table of load vectors walked by one loop, then directed tests for read-back, reset and lock-out.
module test_thr_offset_loader;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 9;
    localparam int OW = 14;

    typedef struct packed {
        logic          ld_n;
        logic          we_n;
        logic [SW-1:0] d;
        logic [OW-1:0] exp_e;
        logic [OW-1:0] exp_f;
    } vec_t;

    // Starts after a programmable-mode reset (both thresholds 7, pointer at slot 0).
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 9'h023, 14'h0023, 14'h0007},  // R3 R4 slot 0
        '{1'b0, 1'b0, 9'h001, 14'h0223, 14'h0007},  // R4 slot 1
        '{1'b1, 1'b0, 9'h1FF, 14'h0223, 14'h0007},  // R6 load high
        '{1'b0, 1'b1, 9'h1AA, 14'h0223, 14'h0007},  // R6 write enable high
        '{1'b0, 1'b0, 9'h0F0, 14'h0223, 14'h00F0},  // R4 slot 2
        '{1'b0, 1'b0, 9'h1FF, 14'h0223, 14'h3EF0},  // R7 slot 3, truncated
        '{1'b0, 1'b0, 9'h005, 14'h0205, 14'h3EF0},  // R5 wrap to slot 0
        '{1'b0, 1'b0, 9'h000, 14'h0005, 14'h3EF0}   // R5 slot 1 again
    };

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n = 1'b1;
    logic          wr_en_n = 1'b1;
    logic          rd_en_a_n = 1'b1;
    logic          rd_en_b_n = 1'b1;
    logic [SW-1:0] wdata = '0;
    logic [OW-1:0] empty_offset;
    logic [OW-1:0] full_offset;
    logic [SW-1:0] rb_data;

    int n_chk = 0;
    int n_bad = 0;

    thr_offset_loader i_thr_offset_loader (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
        .wr_en_n(wr_en_n), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
        .wdata(wdata), .empty_offset(empty_offset), .full_offset(full_offset),
        .rb_data(rb_data)
    );

    initial forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #(CLK_PERIOD/2) rd_clk = ~rd_clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Passes one whole cycle (one edge of each clock); sampling happens at the negedge of wr_clk.
    task automatic step();
        @(negedge wr_clk);
    endtask

    task automatic do_reset(input logic ld_level);
        ld_n = ld_level; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1; ld_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        step();
        do_reset(1'b0);
        chk("R1 empty default", 32'(empty_offset), 32'd7);
        chk("R1 full default", 32'(full_offset), 32'd7);
        chk("R1 rb default", 32'(rb_data), 32'd0);

        foreach (VECS[i]) begin
            ld_n = VECS[i].ld_n; wr_en_n = VECS[i].we_n; wdata = VECS[i].d;
            step();
            chk("R3/R4/R5/R6/R7 empty", 32'(empty_offset), 32'(VECS[i].exp_e));
            chk("R3/R4/R5/R6/R7 full", 32'(full_offset), 32'(VECS[i].exp_f));
        end

        // R8: read back all four slots in order, then wrap
        ld_n = 1'b0; wr_en_n = 1'b1; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        step(); chk("R8 slot0", 32'(rb_data), 32'h005);
        step(); chk("R8 slot1", 32'(rb_data), 32'h000);
        step(); chk("R8 slot2", 32'(rb_data), 32'h0F0);
        step(); chk("R8 slot3", 32'(rb_data), 32'h1FF);
        step(); chk("R8 wrap", 32'(rb_data), 32'h005);
        // R9: one read enable high holds the value and the pointer
        rd_en_a_n = 1'b1;
        step(); chk("R9 hold", 32'(rb_data), 32'h005);
        rd_en_a_n = 1'b0;
        step(); chk("R9 pointer held", 32'(rb_data), 32'h000);
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; ld_n = 1'b1;
        step();

        // R1: reset in the middle of a sequence restores slot 0 as the next target
        do_reset(1'b0);
        ld_n = 1'b0; wr_en_n = 1'b0; wdata = 9'h011;
        step();
        chk("R1 pointer reset", 32'(empty_offset), 32'h011);
        chk("R1 full after reset", 32'(full_offset), 32'd7);
        ld_n = 1'b1; wr_en_n = 1'b1;

        // R2: reset with the load pin high locks out loads and read-back
        do_reset(1'b1);
        ld_n = 1'b0; wr_en_n = 1'b0; wdata = 9'h155;
        repeat (4) step();
        chk("R2 empty locked", 32'(empty_offset), 32'd7);
        chk("R2 full locked", 32'(full_offset), 32'd7);
        wr_en_n = 1'b1; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        step();
        chk("R2 readback locked", 32'(rb_data), 32'd0);
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; ld_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule